// File: doc/BRIEF.md
# Hash Engine Control Register File

This block is the software-facing control layer of a hash accelerator. A processor reaches it over a small valid/ready register bus with 32-bit little-endian data. It holds the source, destination and key-buffer addresses, the source byte count, a command word and a status word. The hash datapath and its memory traffic sit downstream and are not part of it.

A write to the command word is masked, stored and decoded. If the engine is idle and the algorithm fields name a legal algorithm, the block issues a one-cycle start pulse. The pulse carries a compact algorithm code and the scatter-gather flag. When the engine reports completion, the block sets a sticky done flag in the status word. It raises the interrupt line only if the command that launched the operation asked for one. Software clears both the flag and the interrupt by writing one to the flag.

The command word also has fields for keyed-hash mode and for chaining with a cipher. These are stored and reported on an unsupported-mode output, and nothing more is done with them. The cipher command word is plain storage.

Top module: `hash_ctl_regs`

## Requirements
- R1: After reset every register reads as zero, and `start_o`, `irq_o` and `unsupported_o` are low.
- R2: `req_ready_o` is always high. The word index is `req_addr_i[ADDR_W-1:2]`. A read is answered on the cycle after it is accepted, with `rsp_valid_o` high and `rsp_rdata_o` holding the stored word. The byte offsets are: cipher command 0x10, status 0x1C, source 0x20, destination 0x24, key buffer 0x28, length 0x2C, command 0x30. Every other in-range word is plain 32-bit storage.
- R3: The address and length registers mask the data written to them, as follows:
  - Source keeps `wdata & ADDR_MASK`.
  - Destination keeps `wdata & ADDR_MASK`, with bits 2:0 cleared.
  - Key buffer keeps `wdata & ADDR_MASK`, with bits 5:0 cleared when `KEY_ALIGN64`=1 and bits 2:0 cleared otherwise.
  - Length keeps bits 27:0 only.
- R4: A command write stores `wdata & HASH_MASK`, and decoding uses that masked value.
- R5: Command bits 6:4 select the algorithm, and `algo_o` carries the matching code:
  - 000 selects MD5, code 0.
  - 010 selects SHA-1, code 1.
  - 100 selects SHA-224, code 2.
  - 101 selects SHA-256, code 3.
  - 011 selects the 512-bit family, and bits 12:10 then pick the member: 000 is SHA-512 (code 4), 001 is SHA-384 (code 5), 010 is SHA-512/256 (code 6).
  - Every other combination is invalid.
- R6: A command write that is accepted with a valid selection raises `start_o` for exactly one cycle, on the cycle after the write. `algo_o` holds the code and `sg_o` holds command bit 18. An invalid selection gives no start, but its value is still stored.
- R7: A command write that arrives while `busy_i` is high, or during the start cycle, is dropped: there is no start and the stored command is unchanged.
- R8: A `done_i` pulse sets status bit 9, whether or not the interrupt is enabled.
- R9: On `done_i`, `irq_o` rises only if bit 9 of the command that started the operation was set.
- R10: Writing to status with bit 9 = 1 clears status bit 9 and drops `irq_o`. The other status bits store the written value. If `done_i` arrives in the same cycle as the clear, the flag ends up set.
- R11: `unsupported_o` is high whenever the stored command has bits 8:7 nonzero or bit 1 set.
- R12: A word index at or above `NUM_REGS` reads as zero, and a write to it changes no register.
- R13: A write to the cipher command word is stored and never starts the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request ready (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| start_o | output | 1 | One-cycle start to the engine |
| algo_o | output | 3 | Algorithm code for the start |
| sg_o | output | 1 | Scatter-gather source flag for the start |
| busy_i | input | 1 | Engine busy |
| done_i | input | 1 | Engine completion pulse |
| irq_o | output | 1 | Interrupt line |
| unsupported_o | output | 1 | Stored command requests an unsupported mode |

## Verification
The assertions take for granted that `done_i` is a single-cycle pulse and that `busy_i` is driven only by an engine that the block has actually started. Under those conditions the done, interrupt and start relations hold for every bus sequence. The bench models such an engine: after each start it raises `busy_i` for a few cycles, then drops it and pulses `done_i` once. The only time `done_i` arrives without a fresh start is the directed test of a clear colliding with completion, and that test runs after a start whose interrupt enable was zero.

// File: rtl/hash_ctl_pkg.sv
package hash_ctl_pkg;
  typedef enum logic [2:0] {
    ALG_MD5        = 3'd0,
    ALG_SHA1       = 3'd1,
    ALG_SHA224     = 3'd2,
    ALG_SHA256     = 3'd3,
    ALG_SHA512     = 3'd4,
    ALG_SHA384     = 3'd5,
    ALG_SHA512_256 = 3'd6
  } hash_alg_e;

  localparam int unsigned IDX_CIPHER = 4;
  localparam int unsigned IDX_STATUS = 7;
  localparam int unsigned IDX_SRC    = 8;
  localparam int unsigned IDX_DST    = 9;
  localparam int unsigned IDX_KEY    = 10;
  localparam int unsigned IDX_LEN    = 11;
  localparam int unsigned IDX_CMD    = 12;

  localparam int unsigned DONE_BIT   = 9;
  localparam int unsigned IRQ_EN_BIT = 9;
  localparam int unsigned SG_BIT     = 18;

  typedef struct packed {
    logic      ok;
    hash_alg_e alg;
    logic      sg;
    logic      irq_en;
    logic      unsup;
  } cmd_dec_t;
endpackage

// File: rtl/hash_alg_decode.sv
module hash_alg_decode
  import hash_ctl_pkg::*;
(
  input  logic [31:0] cmd_i,
  output cmd_dec_t    dec_o
);
  logic [2:0] fam;
  logic [2:0] sub;
  assign fam = cmd_i[6:4];
  assign sub = cmd_i[12:10];

  always_comb begin
    dec_o.ok     = 1'b1;
    dec_o.alg    = ALG_MD5;
    dec_o.sg     = cmd_i[SG_BIT];
    dec_o.irq_en = cmd_i[IRQ_EN_BIT];
    dec_o.unsup  = (|cmd_i[8:7]) | cmd_i[1];
    unique case (fam)
      3'b000: dec_o.alg = ALG_MD5;
      3'b010: dec_o.alg = ALG_SHA1;
      3'b100: dec_o.alg = ALG_SHA224;
      3'b101: dec_o.alg = ALG_SHA256;
      3'b011: begin
        unique case (sub)
          3'b000:  dec_o.alg = ALG_SHA512;
          3'b001:  dec_o.alg = ALG_SHA384;
          3'b010:  dec_o.alg = ALG_SHA512_256;
          default: dec_o.ok  = 1'b0;
        endcase
      end
      default: dec_o.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/hash_done_irq.sv
module hash_done_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic irq_en_i,
  input  logic done_i,
  input  logic clr_i,
  output logic done_o,
  output logic irq_o
);
  logic irq_en_q, done_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (start_i) irq_en_q <= irq_en_i;
      // completion wins over a simultaneous clear
      if (done_i) begin
        done_q <= 1'b1;
        irq_q  <= irq_q | irq_en_q;
      end else if (clr_i) begin
        done_q <= 1'b0;
        irq_q  <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign irq_o  = irq_q;

  // R9
  irq_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
  // R8
  done_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_o);
  // R10
  clear_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_i) |=> (!irq_o && !done_o));
  // R9
  irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i));
endmodule

// File: rtl/hash_ctl_regs.sv
module hash_ctl_regs
  import hash_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NUM_REGS    = 13,
  parameter logic [31:0] ADDR_MASK   = 32'h7FFF_FFFF,
  parameter bit          KEY_ALIGN64 = 1'b0,
  parameter logic [31:0] HASH_MASK   = 32'h0014_7FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              start_o,
  output logic [2:0]        algo_o,
  output logic              sg_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              irq_o,
  output logic              unsupported_o
);
  localparam int unsigned IDX_W    = ADDR_W - 2;
  localparam logic [31:0] KEY_LOW  = KEY_ALIGN64 ? 32'h0000_003F : 32'h0000_0007;
  localparam logic [31:0] DONE_MSK = 32'h1 << DONE_BIT;

  function automatic logic [31:0] wr_mask(int unsigned i);
    case (i)
      IDX_SRC:    return ADDR_MASK;
      IDX_DST:    return ADDR_MASK & ~32'h7;
      IDX_KEY:    return ADDR_MASK & ~KEY_LOW;
      IDX_LEN:    return 32'h0FFF_FFFF;
      IDX_CMD:    return HASH_MASK;
      IDX_STATUS: return ~DONE_MSK;
      default:    return 32'hFFFF_FFFF;
    endcase
  endfunction

  logic [IDX_W-1:0] idx;
  logic             in_range, wr_en, rd_en, eng_busy;
  logic             cmd_wr, cmd_take, stat_clr, done_flag;
  logic [31:0]      reg_q [NUM_REGS];
  logic [31:0]      cmd_masked, rd_word;
  cmd_dec_t         dec;
  logic             start_q, sg_q;
  hash_alg_e        alg_q;
  logic             rsp_valid_q;
  logic [31:0]      rdata_q;

  assign req_ready_o = 1'b1;
  assign idx         = req_addr_i[ADDR_W-1:2];
  assign in_range    = idx < IDX_W'(NUM_REGS);
  assign wr_en       = req_valid_i & req_write_i & in_range;
  assign rd_en       = req_valid_i & ~req_write_i;
  assign eng_busy    = busy_i | start_q;
  assign cmd_masked  = req_wdata_i & HASH_MASK;
  assign cmd_wr      = wr_en & (idx == IDX_W'(IDX_CMD));
  assign cmd_take    = cmd_wr & ~eng_busy;
  assign stat_clr    = wr_en & (idx == IDX_W'(IDX_STATUS)) & req_wdata_i[DONE_BIT];

  hash_alg_decode u_dec (
    .cmd_i (cmd_masked),
    .dec_o (dec)
  );

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    localparam logic [31:0] WMASK  = wr_mask(gi);
    localparam bit          IS_CMD = (gi == IDX_CMD);
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(gi)) && (!IS_CMD || !eng_busy);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  reg_q[gi] <= '0;
      else if (hit) reg_q[gi] <= req_wdata_i & WMASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      alg_q   <= ALG_MD5;
      sg_q    <= 1'b0;
    end else begin
      start_q <= cmd_take & dec.ok;
      if (cmd_take & dec.ok) begin
        alg_q <= dec.alg;
        sg_q  <= dec.sg;
      end
    end
  end

  hash_done_irq u_done (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cmd_take & dec.ok),
    .irq_en_i (dec.irq_en),
    .done_i   (done_i),
    .clr_i    (stat_clr),
    .done_o   (done_flag),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_word = '0;
    for (int unsigned i = 0; i < NUM_REGS; i++) begin
      if (in_range && idx == IDX_W'(i)) rd_word = reg_q[i];
    end
    if (in_range && idx == IDX_W'(IDX_STATUS)) rd_word = rd_word | (done_flag ? DONE_MSK : 32'h0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= rd_en;
      if (rd_en) rdata_q <= rd_word;
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_rdata_o   = rdata_q;
  assign start_o       = start_q;
  assign algo_o        = alg_q;
  assign sg_o          = sg_q;
  assign unsupported_o = (|reg_q[IDX_CMD][8:7]) | reg_q[IDX_CMD][1];

  // R6
  start_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R6
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(req_valid_i && req_write_i && !busy_i));
  // R7
  busy_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_i) |=> (!start_o && $stable(reg_q[IDX_CMD])));
  // R5
  algo_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (algo_o <= 3'd6));
  // R2
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
endmodule

// File: tb/hash_ctl_regs_tb.sv
module hash_ctl_regs_tb;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned NREG      = 13;
  localparam logic [31:0] AMASK     = 32'h7FFF_FFFF;
  localparam logic [31:0] HMASK     = 32'h0014_7FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic busy = 1'b0, done = 1'b0;
  logic req_ready, rsp_valid, start, sg, irq, unsup;
  logic [31:0] rsp_rdata;
  logic [2:0] algo;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp [NREG];
  logic exp_done = 0, exp_irq = 0, exp_ien = 0;

  always #4 clk = ~clk;

  hash_ctl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .start_o(start),
    .algo_o(algo), .sg_o(sg), .busy_i(busy), .done_i(done), .irq_o(irq),
    .unsupported_o(unsup)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] fmask(int unsigned i);
    case (i)
      8:  return AMASK;
      9:  return AMASK & 32'hFFFF_FFF8;
      10: return AMASK & 32'hFFFF_FFF8;
      11: return 32'h0FFF_FFFF;
      12: return HMASK;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // returns {ok, code}
  function automatic logic [3:0] dec(logic [31:0] c);
    case (c[6:4])
      3'b000: return 4'h8;
      3'b010: return 4'h9;
      3'b100: return 4'hA;
      3'b101: return 4'hB;
      3'b011: case (c[12:10])
        3'b000: return 4'hC;
        3'b001: return 4'hD;
        3'b010: return 4'hE;
        default: return 4'h0;
      endcase
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [31:0] valid_sel(int unsigned k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0020;
      2: return 32'h0000_0040;
      3: return 32'h0000_0050;
      4: return 32'h0000_0030;
      5: return 32'h0000_0430;
      default: return 32'h0000_0830;
    endcase
  endfunction

  task automatic bus_write(int unsigned wi, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(wi << 2); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(int unsigned wi, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(wi << 2);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", 32'(rsp_valid), 32'h1);
    d = rsp_rdata;
  endtask

  function automatic logic [31:0] exp_read(int unsigned i);
    if (i >= NREG) return 32'h0;
    if (i == 7) return exp[7] | (exp_done ? 32'h200 : 32'h0);
    return exp[i];
  endfunction

  task automatic check_all(string tag);
    logic [31:0] d;
    for (int unsigned i = 0; i < NREG; i++) begin
      bus_read(i, d);
      chk(tag, d, exp_read(i));
    end
  endtask

  task automatic finish_op();
    logic [31:0] d;
    @(negedge clk); busy = 1'b0; done = 1'b1;
    @(negedge clk); done = 1'b0;
    exp_done = 1'b1;
    exp_irq = exp_irq | exp_ien;
    chk("R9 irq after done", 32'(irq), 32'(exp_irq));
    bus_read(7, d);
    chk("R8 done flag", 32'(d[9]), 32'h1);
    d = $urandom | 32'h200;
    bus_write(7, d);
    exp[7] = d & ~32'h200; exp_done = 1'b0; exp_irq = 1'b0;
    chk("R10 irq cleared", 32'(irq), 32'h0);
    bus_read(7, d);
    chk("R10 status after clear", d, exp[7]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R6 actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c, cm;
    logic [3:0] de;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) exp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 start", 32'(start), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 unsupported", 32'(unsup), 32'h0);
    chk("R2 ready", 32'(req_ready), 32'h1);
    check_all("R1 reset value");

    // R2 / R3 / R13 random register traffic
    for (int n = 0; n < 60; n++) begin
      int unsigned wi;
      string tag;
      wi = $urandom_range(0, 11);
      if (wi == 7) wi = 8;
      d = (n < 4) ? 32'hFFFF_FFFF : $urandom;
      bus_write(wi, d);
      if (wi == 4) chk("R13 no start", 32'(start), 32'h0);
      exp[wi] = d & fmask(wi);
      tag = (wi >= 8) ? "R3 masked write" : (wi == 4 ? "R13 cipher stored" : "R2 plain word");
      bus_read(wi, c);
      chk(tag, c, exp[wi]);
    end

    // command traffic
    for (int n = 0; n < 80; n++) begin
      c = $urandom;
      if (n % 2 == 0) c = (c & ~32'h0000_1C70) | valid_sel($urandom_range(0, 6));
      cm = c & HMASK;
      de = dec(cm);
      bus_write(12, c);
      exp[12] = cm;
      chk("R6 start", 32'(start), 32'(de[3]));
      if (de[3]) begin
        chk("R5 algo code", 32'(algo), 32'(de[2:0]));
        chk("R6 sg flag", 32'(sg), 32'(cm[18]));
        exp_ien = cm[9];
      end
      chk("R11 unsupported", 32'(unsup), 32'((|cm[8:7]) | cm[1]));
      @(negedge clk);
      chk("R6 single pulse", 32'(start), 32'h0);
      busy = de[3];
      bus_read(12, d);
      chk("R4 stored command", d, exp[12]);
      if (de[3]) begin
        bus_write(12, valid_sel(n % 7));
        chk("R7 no start when busy", 32'(start), 32'h0);
        bus_read(12, d);
        chk("R7 command unchanged", d, exp[12]);
        finish_op();
      end
    end

    // R10 clear colliding with completion; prior start has interrupt disabled
    bus_write(12, 32'h0000_0020);
    exp[12] = 32'h20; exp_ien = 1'b0;
    chk("R6 start sha1", 32'(start), 32'h1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(7 << 2); req_wdata = 32'h200; done = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; done = 1'b0;
    exp[7] = 32'h0; exp_done = 1'b1;
    chk("R9 irq stays low", 32'(irq), 32'h0);
    bus_read(7, d);
    chk("R10 done wins over clear", d, 32'h200);
    bus_write(7, 32'h200); exp_done = 1'b0;

    // R12 out-of-range words
    for (int n = 0; n < 12; n++) begin
      int unsigned wi;
      wi = $urandom_range(NREG, (1 << (ADDR_W - 2)) - 1);
      bus_write(wi, $urandom);
      bus_read(wi, d);
      chk("R12 out of range reads zero", d, 32'h0);
    end
    check_all("R12 no aliasing");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule